// File: doc/BRIEF.md
# Static Memory Write Wait-State Sequencer

This block drives the active-low chip-select and write-enable strobes for a single write to an external static memory. A start request, taken only while the block is idle, loads a programmed write wait-state count; both strobes go low on the next clock edge. The strobes stay low while an internal countdown runs. Programmed counts below three are raised to three.

An active-low wait input from the memory can stretch the access. Samples taken early in the countdown are ignored. The sample taken in the final counting cycle decides whether the access is stretched. If that sample is low, the countdown parks there for as long as the input stays low. After the input is seen high again, a fixed five-cycle completion tail runs before the strobes rise.

A hold timer bounds the stretch. If the wait input is still low when the timer expires, the access is cut short and an error flag is pulsed. Every access ends with a one-cycle done pulse, and busy falls on the cycle after that pulse.

Top module: `smw_write_seq`

## Requirements
- R1: After reset, `cs_no` and `we_no` are high and `busy_o`, `done_o` and `err_o` are low.
- R2: A start request seen at a clock edge while idle drives `cs_no` and `we_no` low together on that same edge and raises `busy_o`; the two strobes always carry equal values.
- R3: With the wait input held high, the strobes stay low for exactly W cycles, where W is the programmed count `wst_i` captured with the start request.
- R4: A captured count of 0, 1 or 2 is treated as W = 3.
- R5: Number the low-strobe cycles from 1. Wait-input levels sampled at the end of cycles 1 to W-1 have no effect on the access length.
- R6: If the wait input is low at the end of cycle W and stays low through the end of cycle b, then goes high, the strobes stay low for b+6 cycles. This holds provided b < W+TIMEOUT.
- R7: Both strobes rise on the same edge. `done_o` is high for exactly the first cycle with high strobes, and `busy_o` is low on the following cycle.
- R8: If the wait input is still low at the end of cycle W+TIMEOUT, the strobes rise after W+TIMEOUT low cycles and `err_o` pulses in the `done_o` cycle. `err_o` stays low in every other case.
- R9: A start request seen while `busy_o` is high, including in the done cycle, is ignored. It does not change the access length and does not begin a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-write request |
| wst_i | input | WST_W | Programmed write wait-state count |
| wait_ni | input | 1 | External wait request, active low |
| cs_no | output | 1 | Chip select, active low |
| we_no | output | 1 | Write enable, active low |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| err_o | output | 1 | Wait timeout, pulses with done_o |

## Verification
Two events can fall on the same cycle: the hold timer expiring and the wait input being released. These decide between the timeout path (R8) and the completion tail (R6). The bench provokes this by sweeping the release point b across W+TIMEOUT-1, W+TIMEOUT and beyond, for every programmed count. It judges each run by the measured number of low-strobe cycles and by the presence of the error pulse. A second collision, a start request during busy or during the done cycle, is injected into every access. The bench then confirms that the access length is unchanged and that the block is idle afterwards.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_HOLD,
    ST_QUE,
    ST_DONE
  } smw_st_e;

  localparam int MIN_WST = 3;
  localparam int QUE_LEN = 5;
endpackage

// File: rtl/smw_down.sv
module smw_down #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/smw_hold_tmr.sv
module smw_hold_tmr #(
  parameter int TIMEOUT = 16365,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + TW'(1);
  end

  assign exp_o = (cnt_q == TW'(TIMEOUT - 1));
endmodule

// File: rtl/smw_fsm.sv
module smw_fsm
  import smw_pkg::*;
#(
  parameter int WST_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WST_W-1:0] wst_i,
  input  logic             wait_ni,
  input  logic             cnt_last_i,
  input  logic             tmr_exp_i,
  output logic             cnt_load_o,
  output logic [WST_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic             cs_no,
  output logic             we_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  smw_st_e st_q, st_d;
  logic abort;
  logic strobe_d;
  logic [WST_W-1:0] wst_eff;

  assign wst_eff = (wst_i < WST_W'(MIN_WST)) ? WST_W'(MIN_WST) : wst_i;

  always_comb begin
    st_d       = st_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = wst_eff;
    cnt_dec_o  = 1'b0;
    tmr_clr_o  = 1'b0;
    tmr_en_o   = 1'b0;
    abort      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d       = ST_ACT;
        cnt_load_o = 1'b1;
      end
      ST_ACT: begin
        if (cnt_last_i) begin
          // only the final counting sample can park the countdown
          if (!wait_ni) begin
            st_d      = ST_HOLD;
            tmr_clr_o = 1'b1;
          end else begin
            st_d = ST_DONE;
          end
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (wait_ni) begin
          st_d       = ST_QUE;
          cnt_load_o = 1'b1;
          cnt_val_o  = WST_W'(QUE_LEN);
        end else if (tmr_exp_i) begin
          st_d  = ST_DONE;
          abort = 1'b1;
        end else begin
          tmr_en_o = 1'b1;
        end
      end
      ST_QUE: begin
        if (cnt_last_i) st_d = ST_DONE;
        else            cnt_dec_o = 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign strobe_d = (st_d == ST_ACT) || (st_d == ST_HOLD) || (st_d == ST_QUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_no  <= 1'b1;
      we_no  <= 1'b1;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_no  <= !strobe_d;
      we_no  <= !strobe_d;
      busy_o <= (st_d != ST_IDLE);
      done_o <= (st_d == ST_DONE);
      err_o  <= abort;
    end
  end
endmodule

// File: rtl/smw_write_seq.sv
module smw_write_seq #(
  parameter int WST_W   = 8,
  parameter int TIMEOUT = 16365
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WST_W-1:0] wst_i,
  input  logic             wait_ni,
  output logic             cs_no,
  output logic             we_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic             cnt_load, cnt_dec, cnt_last;
  logic [WST_W-1:0] cnt_val;
  logic             tmr_clr, tmr_en, tmr_exp;

  smw_fsm #(.WST_W(WST_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wst_i      (wst_i),
    .wait_ni    (wait_ni),
    .cnt_last_i (cnt_last),
    .tmr_exp_i  (tmr_exp),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cnt_dec_o  (cnt_dec),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en),
    .cs_no      (cs_no),
    .we_no      (we_no),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  smw_down #(.W(WST_W)) u_down (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .last_o (cnt_last)
  );

  smw_hold_tmr #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .exp_o  (tmr_exp)
  );
endmodule

// File: rtl/smw_write_seq_chk.sv
module smw_write_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_no,
  input logic we_no,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  a_r2_strobes_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no == we_no);

  a_r2_start_begins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i) && !$past(busy_o));

  a_r4_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !cs_no ##1 !cs_no);

  a_r7_done_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no && !done_o && !err_o);
endmodule

bind smw_write_seq smw_write_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .cs_no   (cs_no),
  .we_no   (we_no),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/smw_write_seq_test.sv
module smw_write_seq_test;
  localparam int WW = 4;
  localparam int TO = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [WW-1:0] wst_i = '0;
  logic          wait_ni = 1'b1;
  logic          cs_no, we_no, busy_o, done_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  smw_write_seq #(.WST_W(WW), .TIMEOUT(TO)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .wst_i   (wst_i),
    .wait_ni (wait_ni),
    .cs_no   (cs_no),
    .we_no   (we_no),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one access; wait low over low-cycles a..b (a>b: never)
  task automatic run_access(input int w, input int a, input int b);
    int weff, exp_len, exp_err, len;
    weff = (w < 3) ? 3 : w;
    if (a <= weff && weff <= b) begin
      if (b >= weff + TO) begin exp_len = weff + TO; exp_err = 1; end
      else begin exp_len = b + 6; exp_err = 0; end
    end else begin
      exp_len = weff; exp_err = 0;
    end
    @(negedge clk_i);
    start_i = 1'b1;
    wst_i   = WW'(w);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    len = 0;
    while (!cs_no && len < 100) begin
      len++;
      if (we_no != cs_no) chk("R2 we equals cs", int'(we_no), int'(cs_no));
      wait_ni = !(len >= a && len <= b);
      // R9: restart attempt mid-access
      start_i = (len == 2);
      wst_i   = (len == 2) ? WW'(0) : WW'(w);
      if (err_o) chk("R8 err early", 1, 0);
      @(negedge clk_i);
    end
    wait_ni = 1'b1;
    start_i = 1'b1;  // R9: start in done cycle
    chk((exp_err != 0) ? "R8 timeout length" : "R3 R5 R6 length", len, exp_len);
    chk("R7 we rises with cs", int'(we_no), 1);
    chk("R7 done pulse", int'(done_o), 1);
    chk("R8 err flag", int'(err_o), exp_err);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7 R9 busy falls", int'(busy_o), 0);
    chk("R9 no restart", int'(cs_no), 1);
    chk("R7 done single", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cs", int'(cs_no), 1);
    chk("R1 we", int'(we_no), 1);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R3 R4: plain sweep over every programmed count
    for (int w = 0; w < (1 << WW); w++) run_access(w, 1, 0);
    // R5 R6 R8: wait windows around the parking cycle and timeout edge
    for (int w = 0; w < (1 << WW); w++) begin
      int weff;
      weff = (w < 3) ? 3 : w;
      for (int ai = 0; ai < 4; ai++) begin
        int a;
        a = (ai == 0) ? 1 : (ai == 1) ? weff - 2 : (ai == 2) ? weff : weff + 1;
        for (int bi = 0; bi < 6; bi++) begin
          int b;
          b = (bi == 0) ? weff - 1 : (bi == 1) ? weff : (bi == 2) ? weff + 3 :
              (bi == 3) ? weff + TO - 1 : (bi == 4) ? weff + TO : weff + TO + 2;
          if (b >= a) run_access(w, a, b);
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule